// File: doc/BRIEF.md
# Fixed-Point First-Order Recursive Lowpass

This block is a streaming first-order lowpass for signed 16-bit samples. It keeps a single state register in transposed form. Each accepted sample x gives y = b·x + z. The state is then replaced by z = b·x + f·y, where f = −a1 is the feedback coefficient and y is the rounded and saturated output. Because both numerator taps share the single coefficient b, the zero sits exactly at Nyquist, and with matched coefficients the gain at DC is unity.

Coefficients are signed Q1.15 words and can be reloaded at run time. After reset they take values designed for a 1 kHz corner at a 44.1 kHz sample rate: b = 2183 and f = 28403. The datapath is a two-stage pipeline. The first stage registers the numerator product b·x and a snapshot of f. The second stage accumulates with the state in a Q2.30 accumulator of at least 32 bits, rounds back to Q1.15, saturates, and updates the state. The block accepts one sample per cycle.

Top module: `iir1_lp`

## Requirements
- R1: While rst_ni is low and after its release, out_valid_o is 0 and out_data_o is 0, and the state is zero. With default coefficients, a first sample of 1000 yields 67.
- R2: Each output is y = sat(round(b·x + z)). Here b·x is the full Q2.30 product of the sample and the numerator coefficient, and z is the stored state.
- R3: After each output the state becomes z = b·x + f·y, held at full accumulator precision. It uses the same sample and the saturated output y.
- R4: Rounding adds 2^14 to the Q2.30 sum and then shifts it arithmetically right by 15 (round half up). With b = 16384 and f = 0, from zero state, an input of −1 gives 0 and an input of 1 gives 1.
- R5: The rounded result saturates to −32768..32767 before it is output or fed back. With b = f = 32767, a held input of 32767 gives 32767 and a held input of −32768 gives −32768.
- R6: A sample is accepted on a rising edge with in_valid_i high. Its output appears with out_valid_o high for exactly one cycle after the following rising edge. There is one output per accepted sample and no other out_valid_o pulse. out_data_o holds its value while out_valid_o is low.
- R7: A write is a rising edge with coef_we_i high. It loads coef_num_i as b and coef_fb_i as f, both signed Q1.15, with f = −a1. Reset restores b = 2183 and f = 28403. A sample uses the coefficients in force at its accepting edge, even if a write lands while the sample is still in the pipeline.
- R8: With default coefficients, a held constant input settles to within 3 LSB of that input.
- R9: With default coefficients, an input alternating between +32767 and −32767 settles to an output of magnitude at most 3.
- R10: Cycles with in_valid_i low leave the state unchanged. Samples may arrive back-to-back or with gaps, and the output sequence is the same either way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| coef_we_i | input | 1 | Coefficient write strobe |
| coef_num_i | input | 16 | Numerator coefficient b, signed Q1.15 |
| coef_fb_i | input | 16 | Feedback coefficient f = −a1, signed Q1.15 |
| in_valid_i | input | 1 | Input sample strobe |
| in_data_i | input | 16 | Input sample, signed Q1.15 |
| out_valid_o | output | 1 | Output sample strobe |
| out_data_o | output | 16 | Output sample, signed Q1.15 |

## Verification
Every output is compared bit for bit against an integer model of the recursion. A design that dropped state precision, fed back the unsaturated value, or rounded toward zero would drift off that model within a few samples of the step. A mode that went wrong only on negative inputs is exposed by a ±full-scale Nyquist pattern and a negative DC run. Half-way values of −0.5 and +0.5 catch rounding that is symmetric or truncating, and full-scale inputs with large coefficients catch a design that wraps instead of clipping. A coefficient write that lands while a sample is between stages catches a design that reads the new feedback value too early. Idle gaps between samples catch a state register that updates without a sample.

// File: rtl/iir1_lp_pkg.sv
package iir1_lp_pkg;
  parameter int unsigned DATA_W_DEF = 16;
  parameter int unsigned COEF_W_DEF = 16;
  parameter int unsigned GUARD_DEF  = 4;
  // 1 kHz corner at 44.1 kHz, Q1.15
  parameter int NUM_RST_DEF = 2183;
  parameter int FB_RST_DEF  = 28403;
endpackage

// File: rtl/iir1_lp_coef.sv
module iir1_lp_coef #(
  parameter int unsigned COEF_W  = 16,
  parameter int          NUM_RST = 2183,
  parameter int          FB_RST  = 28403
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic signed [COEF_W-1:0] num_i,
  input  logic signed [COEF_W-1:0] fb_i,
  output logic signed [COEF_W-1:0] num_o,
  output logic signed [COEF_W-1:0] fb_o
);
  localparam logic signed [COEF_W-1:0] NUM_INIT = COEF_W'(NUM_RST);
  localparam logic signed [COEF_W-1:0] FB_INIT  = COEF_W'(FB_RST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      num_o <= NUM_INIT;
      fb_o  <= FB_INIT;
    end else if (we_i) begin
      num_o <= num_i;
      fb_o  <= fb_i;
    end
  end
endmodule

// File: rtl/iir1_lp_mul_stage.sv
module iir1_lp_mul_stage #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned COEF_W = 16,
  localparam int unsigned PROD_W = DATA_W + COEF_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] data_i,
  input  logic signed [COEF_W-1:0] num_i,
  input  logic signed [COEF_W-1:0] fb_i,
  output logic                     valid_o,
  output logic signed [PROD_W-1:0] prod_o,
  output logic signed [COEF_W-1:0] fb_o
);
  logic signed [PROD_W-1:0] prod_d;

  // b0 == b1: one product serves output and state update
  always_comb prod_d = data_i * num_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      prod_o  <= '0;
      fb_o    <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        prod_o <= prod_d;
        fb_o   <= fb_i; // snapshot: sample keeps its own feedback coefficient
      end
    end
  end
endmodule

// File: rtl/iir1_lp_core.sv
module iir1_lp_core #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned COEF_W = 16,
  parameter int unsigned GUARD  = 4,
  localparam int unsigned PROD_W = DATA_W + COEF_W,
  localparam int unsigned ACC_W  = PROD_W + GUARD,
  localparam int unsigned FRAC   = COEF_W - 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [PROD_W-1:0] prod_i,
  input  logic signed [COEF_W-1:0] fb_i,
  output logic                     valid_o,
  output logic signed [DATA_W-1:0] data_o,
  output logic signed [ACC_W-1:0]  state_o
);
  localparam int YMAX = 2 ** (DATA_W - 1) - 1;
  localparam int YMIN = -(2 ** (DATA_W - 1));
  localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'(YMAX);
  localparam logic signed [ACC_W-1:0] SAT_LO = ACC_W'(YMIN);
  localparam logic signed [ACC_W-1:0] HALF   = ACC_W'(1) <<< (FRAC - 1);

  logic signed [ACC_W-1:0]  prod_x, acc, rnd, shf, fbp_x, state_d;
  logic signed [PROD_W-1:0] fbp;
  logic signed [DATA_W-1:0] y;

  always_comb begin
    prod_x = {{GUARD{prod_i[PROD_W-1]}}, prod_i};
    acc    = prod_x + state_o;
    rnd    = acc + HALF;
    shf    = rnd >>> FRAC;
    if (shf > SAT_HI)      y = SAT_HI[DATA_W-1:0];
    else if (shf < SAT_LO) y = SAT_LO[DATA_W-1:0];
    else                   y = shf[DATA_W-1:0];
    fbp     = fb_i * y;
    fbp_x   = {{GUARD{fbp[PROD_W-1]}}, fbp};
    state_d = prod_x + fbp_x;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      state_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        data_o  <= y;
        state_o <= state_d;
      end
    end
  end
endmodule

// File: rtl/iir1_lp.sv
module iir1_lp
  import iir1_lp_pkg::*;
#(
  parameter int unsigned DATA_W  = DATA_W_DEF,
  parameter int unsigned COEF_W  = COEF_W_DEF,
  parameter int unsigned GUARD   = GUARD_DEF,
  parameter int          NUM_RST = NUM_RST_DEF,
  parameter int          FB_RST  = FB_RST_DEF,
  localparam int unsigned PROD_W = DATA_W + COEF_W,
  localparam int unsigned ACC_W  = PROD_W + GUARD
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              coef_we_i,
  input  logic [COEF_W-1:0] coef_num_i,
  input  logic [COEF_W-1:0] coef_fb_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o
);
  logic signed [COEF_W-1:0] coef_num_q, coef_fb_q, s0_fb;
  logic signed [PROD_W-1:0] s0_prod;
  logic signed [DATA_W-1:0] y_q;
  logic signed [ACC_W-1:0]  state_q;
  logic                     s0_valid;

  iir1_lp_coef #(
    .COEF_W (COEF_W),
    .NUM_RST(NUM_RST),
    .FB_RST (FB_RST)
  ) coef_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (coef_we_i),
    .num_i (coef_num_i),
    .fb_i  (coef_fb_i),
    .num_o (coef_num_q),
    .fb_o  (coef_fb_q)
  );

  iir1_lp_mul_stage #(
    .DATA_W(DATA_W),
    .COEF_W(COEF_W)
  ) mul_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(in_valid_i),
    .data_i (in_data_i),
    .num_i  (coef_num_q),
    .fb_i   (coef_fb_q),
    .valid_o(s0_valid),
    .prod_o (s0_prod),
    .fb_o   (s0_fb)
  );

  iir1_lp_core #(
    .DATA_W(DATA_W),
    .COEF_W(COEF_W),
    .GUARD (GUARD)
  ) core_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(s0_valid),
    .prod_i (s0_prod),
    .fb_i   (s0_fb),
    .valid_o(out_valid_o),
    .data_o (y_q),
    .state_o(state_q)
  );

  assign out_data_o = y_q;
endmodule

// File: rtl/iir1_lp_chk.sv
module iir1_lp_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned COEF_W = 16,
  parameter int unsigned ACC_W  = 36
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              coef_we_i,
  input logic [COEF_W-1:0] coef_num_i,
  input logic [COEF_W-1:0] coef_fb_i,
  input logic              in_valid_i,
  input logic              out_valid_o,
  input logic [DATA_W-1:0] out_data_o,
  input logic [COEF_W-1:0] coef_num_q,
  input logic [COEF_W-1:0] coef_fb_q,
  input logic [ACC_W-1:0]  state_q
);
  logic v1, v2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
    end else begin
      v1 <= in_valid_i;
      v2 <= v1;
    end
  end

  // R6
  out_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == v2);

  // R6
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> $stable(out_data_o));

  // R7
  coef_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coef_we_i |=> (coef_num_q == $past(coef_num_i)) && (coef_fb_q == $past(coef_fb_i)));

  // R10
  idle_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !v1 |=> $stable(state_q));

  // R1
  reset_out_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!out_valid_o && out_data_o == '0));
endmodule

bind iir1_lp iir1_lp_chk #(
  .DATA_W(DATA_W),
  .COEF_W(COEF_W),
  .ACC_W (ACC_W)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .coef_we_i  (coef_we_i),
  .coef_num_i (coef_num_i),
  .coef_fb_i  (coef_fb_i),
  .in_valid_i (in_valid_i),
  .out_valid_o(out_valid_o),
  .out_data_o (out_data_o),
  .coef_num_q (coef_num_q),
  .coef_fb_q  (coef_fb_q),
  .state_q    (state_q)
);

// File: tb/iir1_lp_tb_top.sv
module iir1_lp_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        coef_we_i = 1'b0;
  logic [15:0] coef_num_i = '0;
  logic [15:0] coef_fb_i = '0;
  logic        in_valid_i = 1'b0;
  logic [15:0] in_data_i = '0;
  logic        out_valid_o;
  logic [15:0] out_data_o;

  iir1_lp dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .coef_we_i  (coef_we_i),
    .coef_num_i (coef_num_i),
    .coef_fb_i  (coef_fb_i),
    .in_valid_i (in_valid_i),
    .in_data_i  (in_data_i),
    .out_valid_o(out_valid_o),
    .out_data_o (out_data_o)
  );

  always #4 clk_i = ~clk_i;

  typedef struct {
    int    y;
    int    cyc;
    string tag;
  } exp_t;

  exp_t   exp_q[$];
  int     n_chk = 0;
  int     n_bad = 0;
  int     cyc = 0;
  int     last_out = 0;
  bit     done = 1'b0;
  int     mb, mfb;
  longint mz;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // bit-exact integer model, from R2..R5
  function automatic int mstep(int x);
    longint p, acc, r;
    int y;
    p   = longint'(mb) * longint'(x);
    acc = p + mz;
    r   = (acc + 64'sd16384) >>> 15;
    if (r > 32767) y = 32767;
    else if (r < -32768) y = -32768;
    else y = int'(r);
    mz = p + longint'(mfb) * longint'(y);
    return y;
  endfunction

  task automatic send(int x, string tag);
    exp_t e;
    e.y = mstep(x);
    e.cyc = cyc + 2;
    e.tag = tag;
    exp_q.push_back(e);
    in_valid_i = 1'b1;
    in_data_i  = 16'(x);
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  task automatic load(int b, int f);
    coef_we_i  = 1'b1;
    coef_num_i = 16'(b);
    coef_fb_i  = 16'(f);
    mb = b;
    mfb = f;
    @(negedge clk_i);
    coef_we_i = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk_i);
    idle(2);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    idle(2);
    check(out_valid_o == 1'b0, "R1 valid in reset", int'(out_valid_o), 0);
    check(out_data_o == 16'h0, "R1 data in reset", int'($signed(out_data_o)), 0);
    rst_ni = 1'b1;
    mz = 0;
    mb = 2183;
    mfb = 28403;
    idle(1);
  endtask

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni && out_valid_o) begin
        last_out = int'($signed(out_data_o));
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected output", last_out, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(last_out == e.y, e.tag, last_out, e.y);
          check(cyc == e.cyc, "R6 latency", cyc, e.cyc);
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    check(1'b0, "watchdog", cyc, 0);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    mb = 2183;
    mfb = 28403;
    mz = 0;
    @(negedge clk_i);
    do_reset();
    check(out_valid_o == 1'b0, "R1 valid after release", int'(out_valid_o), 0);

    // R1 R7: default coefficients, zero state
    send(1000, "R1 first sample");
    drain();
    check(last_out == 67, "R1 R7 default first output", last_out, 67);

    // R2 R3 R8: step into DC
    do_reset();
    for (int i = 0; i < 4; i++) send(0, "R2 step base");
    for (int i = 0; i < 80; i++) send(20000, "R3 step");
    drain();
    check(iabs(last_out - 20000) <= 3, "R8 positive DC settle", last_out, 20000);

    // R10 R8: negative DC with gaps
    for (int i = 0; i < 100; i++) begin
      send(-12345, "R10 gapped DC");
      if (i % 3 == 0) idle(2);
    end
    drain();
    check(iabs(last_out + 12345) <= 3, "R8 negative DC settle", last_out, -12345);

    // R9: Nyquist
    do_reset();
    for (int i = 0; i < 120; i++) send((i % 2 == 0) ? 32767 : -32767, "R9 nyquist");
    drain();
    check(iabs(last_out) <= 3, "R9 nyquist settle", last_out, 0);

    // R5: saturation both ways
    do_reset();
    load(32767, 32767);
    for (int i = 0; i < 6; i++) send(32767, "R5 sat high");
    drain();
    check(last_out == 32767, "R5 clip high", last_out, 32767);
    do_reset();
    load(32767, 32767);
    for (int i = 0; i < 6; i++) send(-32768, "R5 sat low");
    drain();
    check(last_out == -32768, "R5 clip low", last_out, -32768);
    do_reset();
    for (int i = 0; i < 60; i++) send(32767, "R5 default full scale");
    drain();
    check(last_out == 32767, "R5 default full scale clip", last_out, 32767);

    // R4: half-way rounding
    do_reset();
    load(16384, 0);
    send(-1, "R4 minus half");
    drain();
    check(last_out == 0, "R4 minus half rounds up", last_out, 0);
    do_reset();
    load(16384, 0);
    send(1, "R4 plus half");
    drain();
    check(last_out == 1, "R4 plus half rounds up", last_out, 1);

    // R7: write while a sample is in flight
    do_reset();
    for (int i = 0; i < 10; i++) send(5000, "R7 pre-load");
    load(8000, 20000);
    for (int i = 0; i < 10; i++) send(-7000, "R7 post-load");
    load(4000, 30000);
    send(3000, "R7 second load");
    load(2183, 28403);
    for (int i = 0; i < 10; i++) send(3000, "R7 restored");
    drain();

    // R7: reset restores defaults
    do_reset();
    send(1000, "R7 defaults after reset");
    drain();
    check(last_out == 67, "R7 defaults restored", last_out, 67);

    idle(4);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule